// File: doc/BRIEF.md
# Receive Mailbox Bank with Overwrite Slot

This block holds a bank of receive mailboxes for a CAN controller. A frame arrives as one cycle of `frm_valid` with its identifier, extended flag, remote flag, length code and eight data bytes. The frame is stored in the lowest-numbered mailbox that is set to receive and is empty. When every receiving mailbox is full, a mailbox set to overwrite mode takes the frame anyway and records that a message was lost. If no such mailbox is full either, the frame is discarded and a one-cycle drop pulse follows.

Software sets each mailbox's mode through a configuration write. It frees mailboxes with a single mask write, in which each set bit re-arms the mailbox of the same index. A combinational read port returns the packed identifier word, the status word and the data of any mailbox. A ready vector has one bit per mailbox at that mailbox's index, so a driver can tell at a glance which mailboxes hold frames.

Top module: `rx_mbox_bank`

## Requirements
- R1: After reset every mailbox is in mode 0, the ready vector and all lost flags are zero, `drop` is low, and every status word reads 0.
- R2: Mode codes are 0 off, 1 receive and 2 receive-with-overwrite. Codes 3 to 7 are accepted but the mailbox never takes frames. A mode write takes effect from the next cycle.
- R3: A valid frame goes to the lowest-index mailbox in mode 1 or 2 whose ready bit is 0. Its bit in `ready_vec` (bit i for mailbox i) is 1 from the clock edge that samples the frame.
- R4: A full mailbox stays full and keeps its contents until a rearm write has its mask bit set. One rearm write can free any set of mailboxes, and they are free from the next cycle.
- R5: The identifier word has bit 29 set for an extended frame, with the 29-bit identifier in bits 28:0. A standard frame has bit 29 clear, with the 11-bit identifier in bits 28:18. All other bits are 0.
- R6: The status word carries the length code in bits 19:16, the remote flag in bit 20, ready in bit 23 and lost in bit 24. All other bits are 0.
- R7: When no mailbox is free, the lowest full mailbox in mode 2 is overwritten with the new frame and its lost flag is set. Rearming that mailbox clears both ready and lost.
- R8: When no mailbox can take a frame, `drop` is high for exactly the cycle after the frame, and no mailbox's ready bit or contents change.
- R9: The data output returns the stored 64 bits, with byte 0 in bits 7:0.
- R10: A frame arriving in the same cycle as a rearm write is placed using the occupancy that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle frame strobe |
| frm_ide | input | 1 | Extended identifier flag |
| frm_rtr | input | 1 | Remote frame flag |
| frm_id | input | 29 | Identifier (bits 10:0 for standard frames) |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| cfg_we | input | 1 | Mode write strobe |
| cfg_idx | input | IDX_W | Mailbox whose mode is written |
| cfg_mode | input | 3 | New mode code |
| rearm_we | input | 1 | Rearm write strobe |
| rearm_mask | input | NUM_MB | One bit per mailbox to free |
| rd_idx | input | IDX_W | Mailbox selected for reading |
| rd_id_word | output | 32 | Packed identifier of the selected mailbox |
| rd_status | output | 32 | Status word of the selected mailbox |
| rd_data | output | 64 | Data of the selected mailbox |
| ready_vec | output | NUM_MB | Full flag per mailbox |
| drop | output | 1 | Frame discarded, one cycle after the frame |

## Verification
Each registered result is due one cycle after its stimulus. A frame, a rearm or a mode write drives its input for one clock period, and the new occupancy, contents, lost flag and `drop` are visible after the edge that samples it. The bench drives inputs just after a falling edge and checks at the next falling edge, half a period after the sampling edge. The read port is combinational, so the bench changes `rd_idx` and waits a short delay before comparing the words.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

    typedef enum logic [2:0] {
        MB_OFF     = 3'd0,
        MB_RX      = 3'd1,
        MB_RX_OVW  = 3'd2,
        MB_TX      = 3'd3,
        MB_CONS    = 3'd4,
        MB_PROD    = 3'd5
    } mb_mode_e;

    localparam int ID_W   = 29;
    localparam int DATA_W = 64;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] id_word;
        logic              rtr;
        logic [3:0]        dlc;
        logic [DATA_W-1:0] data;
    } mb_slot_t;

    function automatic logic mode_takes_frames(logic [2:0] m);
        return (m == MB_RX) || (m == MB_RX_OVW);
    endfunction

endpackage

// File: rtl/rxmb_first_set.sv
module rxmb_first_set #(
    parameter int W = 8
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant,
    output logic         found
);
    logic [W-1:0] seen;

    always_comb begin
        seen  = '0;
        grant = '0;
        for (int i = 0; i < W; i++) begin
            if (i == 0) begin
                grant[i] = req[i];
                seen[i]  = req[i];
            end else begin
                grant[i] = req[i] & ~seen[i-1];
                seen[i]  = req[i] | seen[i-1];
            end
        end
        found = seen[W-1];
    end
endmodule

// File: rtl/rxmb_id_pack.sv
module rxmb_id_pack
    import rxmb_pkg::*;
(
    input  logic            ide,
    input  logic [ID_W-1:0] id,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        if (ide) word = {2'b00, 1'b1, id};
        else     word = {3'b000, id[10:0], 18'd0};
    end
endmodule

// File: rtl/rxmb_read_port.sv
module rxmb_read_port
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int IDX_W  = 3
) (
    input  mb_slot_t [NUM_MB-1:0] slot,
    input  logic [NUM_MB-1:0]     ready,
    input  logic [NUM_MB-1:0]     lost,
    input  logic [IDX_W-1:0]      idx,
    output logic [WORD_W-1:0]     id_word,
    output logic [WORD_W-1:0]     status,
    output logic [DATA_W-1:0]     data
);
    always_comb begin
        id_word = '0;
        status  = '0;
        data    = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (int'(idx) == i) begin
                id_word = slot[i].id_word;
                data    = slot[i].data;
                status  = {7'd0, lost[i], ready[i], 2'b00,
                           slot[i].rtr, slot[i].dlc, 16'd0};
            end
        end
    end
endmodule

// File: rtl/rx_mbox_bank.sv
module rx_mbox_bank
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 8,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic                frm_ide,
    input  logic                frm_rtr,
    input  logic [28:0]         frm_id,
    input  logic [3:0]          frm_dlc,
    input  logic [63:0]         frm_data,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [2:0]          cfg_mode,
    input  logic                rearm_we,
    input  logic [NUM_MB-1:0]   rearm_mask,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [31:0]         rd_id_word,
    output logic [31:0]         rd_status,
    output logic [63:0]         rd_data,
    output logic [NUM_MB-1:0]   ready_vec,
    output logic                drop
);

    typedef struct packed {
        logic [NUM_MB-1:0][2:0] mode;
        logic [NUM_MB-1:0]      ready;
        logic [NUM_MB-1:0]      lost;
        mb_slot_t [NUM_MB-1:0]  slot;
        logic                   drop;
    } bank_t;

    bank_t st_d, st_q;

    logic [NUM_MB-1:0] free_vec, ovw_vec;
    logic [NUM_MB-1:0] free_grant, ovw_grant;
    logic              free_found, ovw_found;
    logic [NUM_MB-1:0] rearm_m;
    logic [WORD_W-1:0] new_id_word;
    mb_slot_t          new_slot;

    // Per-mailbox eligibility
    for (genvar g = 0; g < NUM_MB; g++) begin : g_elig
        assign free_vec[g] = mode_takes_frames(st_q.mode[g]) & ~st_q.ready[g];
        assign ovw_vec[g]  = (st_q.mode[g] == MB_RX_OVW) & st_q.ready[g];
    end

    rxmb_first_set #(.W(NUM_MB)) i_pick_free (
        .req   (free_vec),
        .grant (free_grant),
        .found (free_found)
    );

    rxmb_first_set #(.W(NUM_MB)) i_pick_ovw (
        .req   (ovw_vec),
        .grant (ovw_grant),
        .found (ovw_found)
    );

    rxmb_id_pack i_id_pack (
        .ide  (frm_ide),
        .id   (frm_id),
        .word (new_id_word)
    );

    assign rearm_m  = rearm_we ? rearm_mask : '0;
    assign new_slot = '{id_word: new_id_word, rtr: frm_rtr, dlc: frm_dlc, data: frm_data};

    always_comb begin
        logic [NUM_MB-1:0] target;
        logic              overwrite;
        st_d       = st_q;
        st_d.drop  = 1'b0;
        st_d.ready = st_q.ready & ~rearm_m;
        st_d.lost  = st_q.lost  & ~rearm_m;
        target     = '0;
        overwrite  = 1'b0;
        if (cfg_we && (int'(cfg_idx) < NUM_MB)) begin
            st_d.mode[cfg_idx] = cfg_mode;
        end
        if (frm_valid) begin
            if (free_found) begin
                target = free_grant;
            end else if (ovw_found) begin
                target    = ovw_grant;
                overwrite = 1'b1;
            end else begin
                st_d.drop = 1'b1;
            end
        end
        for (int i = 0; i < NUM_MB; i++) begin
            if (target[i]) begin
                st_d.slot[i]  = new_slot;
                st_d.ready[i] = 1'b1;
                st_d.lost[i]  = overwrite;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rxmb_read_port #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) i_read (
        .slot    (st_q.slot),
        .ready   (st_q.ready),
        .lost    (st_q.lost),
        .idx     (rd_idx),
        .id_word (rd_id_word),
        .status  (rd_status),
        .data    (rd_data)
    );

    assign ready_vec = st_q.ready;
    assign drop      = st_q.drop;

    // R3: only one free mailbox picked, and none below it was free
    a_r3_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && free_found |-> $onehot0(free_grant) && ((free_vec & (free_grant - 1'b1)) == '0));

    // R3: the picked mailbox is full after the edge
    a_r3_pick_fills: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && free_found |=> |(st_q.ready & $past(free_grant)));

    // R4: a full mailbox not rearmed stays full
    a_r4_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.ready) & ~$past(rearm_m) & ~st_q.ready) == '0));

    // R7: overwrite sets the lost flag of the chosen mailbox
    a_r7_lost_on_ovw: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !free_found && ovw_found |=> |(st_q.lost & st_q.ready & $past(ovw_grant)));

    // R7: lost is only ever set on a full mailbox
    a_r7_lost_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lost & ~st_q.ready) == '0);

    // R8: a frame with no destination leaves occupancy alone and pulses drop
    a_r8_drop_clean: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !free_found && !ovw_found |=> st_q.drop && (st_q.ready == ($past(st_q.ready) & ~$past(rearm_m))));

endmodule

// File: tb/test_rx_mbox_bank.sv
module test_rx_mbox_bank;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [2:0]  cfg_mode = '0;
    logic        rearm_we = 1'b0;
    logic [N-1:0] rearm_mask = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_id_word, rd_status;
    logic [63:0] rd_data;
    logic [N-1:0] ready_vec;
    logic        drop;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rx_mbox_bank #(.NUM_MB(N)) i_rx_mbox_bank (
        .clk, .rst_n, .frm_valid, .frm_ide, .frm_rtr, .frm_id, .frm_dlc, .frm_data,
        .cfg_we, .cfg_idx, .cfg_mode, .rearm_we, .rearm_mask, .rd_idx,
        .rd_id_word, .rd_status, .rd_data, .ready_vec, .drop
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_id(logic ide, logic [28:0] id);
        return ide ? {3'b001, id} : {3'b000, id[10:0], 18'd0};
    endfunction

    function automatic logic [31:0] exp_st(logic lost, logic rdy, logic rtr, logic [3:0] dlc);
        logic [31:0] s = '0;
        s[19:16] = dlc; s[20] = rtr; s[23] = rdy; s[24] = lost;
        return s;
    endfunction

    // Drive one-cycle inputs; results checked after the sampling edge
    task automatic send(logic ide, logic rtr, logic [28:0] id, logic [3:0] dlc, logic [63:0] d,
                        logic do_rearm = 1'b0, logic [N-1:0] m = '0);
        @(negedge clk);
        frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id; frm_dlc = dlc; frm_data = d;
        rearm_we = do_rearm; rearm_mask = m;
        @(negedge clk);
        frm_valid = 1'b0; rearm_we = 1'b0; rearm_mask = '0;
    endtask

    task automatic set_mode(int idx, logic [2:0] md);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_mode = md;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rearm(logic [N-1:0] m);
        @(negedge clk);
        rearm_we = 1'b1; rearm_mask = m;
        @(negedge clk);
        rearm_we = 1'b0; rearm_mask = '0;
    endtask

    task automatic peek(int idx);
        rd_idx = 3'(idx);
        #1;
    endtask

    task automatic t_reset();
        check("R1 ready", 64'(ready_vec), 64'h0);
        check("R1 drop", 64'(drop), 64'h0);
        for (int i = 0; i < N; i++) begin
            peek(i);
            check("R1 status", 64'(rd_status), 64'h0);
        end
    endtask

    task automatic t_all_off_drops();
        send(1'b0, 1'b0, 29'h123, 4'd2, 64'h1);
        check("R2 off mailboxes take nothing", 64'(ready_vec), 64'h0);
        check("R8 drop pulse", 64'(drop), 64'h1);
        @(negedge clk);
        check("R8 drop one cycle", 64'(drop), 64'h0);
    endtask

    task automatic t_lowest_fill();
        for (int i = 0; i < 6; i++) set_mode(i, 3'd1);
        set_mode(6, 3'd3);
        set_mode(7, 3'd2);
        send(1'b0, 1'b0, 29'h5A5, 4'd8, 64'h8877665544332211);
        check("R3 first to mb0", 64'(ready_vec), 64'h01);
        check("R8 no drop", 64'(drop), 64'h0);
        peek(0);
        check("R5 std id", 64'(rd_id_word), 64'(exp_id(1'b0, 29'h5A5)));
        check("R6 status", 64'(rd_status), 64'(exp_st(1'b0, 1'b1, 1'b0, 4'd8)));
        check("R9 data", rd_data, 64'h8877665544332211);
        send(1'b0, 1'b1, 29'h7FF, 4'd0, 64'h0);
        check("R3 second to mb1", 64'(ready_vec), 64'h03);
        peek(1);
        check("R6 rtr status", 64'(rd_status), 64'(exp_st(1'b0, 1'b1, 1'b1, 4'd0)));
        send(1'b1, 1'b0, 29'h1ABCDEF0, 4'd5, 64'h00000000_0000CAFE);
        check("R3 third to mb2", 64'(ready_vec), 64'h07);
        peek(2);
        check("R5 ext id", 64'(rd_id_word), 64'(exp_id(1'b1, 29'h1ABCDEF0)));
        check("R9 data ext", rd_data, 64'h00000000_0000CAFE);
        send(1'b1, 1'b0, 29'h00000001, 4'd1, 64'h33);
        check("R3 fourth to mb3", 64'(ready_vec), 64'h0F);
        peek(0);
        check("R4 mb0 contents held", rd_data, 64'h8877665544332211);
    endtask

    task automatic t_multi_rearm();
        rearm(8'b0000_0101);
        check("R4 multi rearm", 64'(ready_vec), 64'h0A);
        send(1'b0, 1'b0, 29'h010, 4'd1, 64'hA0);
        check("R3 refill lowest mb0", 64'(ready_vec), 64'h0B);
        send(1'b0, 1'b0, 29'h020, 4'd1, 64'hA2);
        check("R3 refill mb2", 64'(ready_vec), 64'h0F);
        send(1'b0, 1'b0, 29'h040, 4'd1, 64'hA4);
        send(1'b0, 1'b0, 29'h050, 4'd1, 64'hA5);
        check("R3 mb5 filled", 64'(ready_vec), 64'h3F);
        send(1'b0, 1'b0, 29'h070, 4'd3, 64'hA7);
        check("R2 mode 3 skipped, mb7 taken", 64'(ready_vec), 64'hBF);
        peek(7);
        check("R7 no lost on free fill", 64'(rd_status), 64'(exp_st(1'b0, 1'b1, 1'b0, 4'd3)));
    endtask

    task automatic t_overwrite();
        send(1'b1, 1'b0, 29'h0BADBEEF, 4'd6, 64'hFEED);
        check("R7 occupancy same", 64'(ready_vec), 64'hBF);
        check("R8 no drop on overwrite", 64'(drop), 64'h0);
        peek(7);
        check("R7 lost set", 64'(rd_status), 64'(exp_st(1'b1, 1'b1, 1'b0, 4'd6)));
        check("R7 new id", 64'(rd_id_word), 64'(exp_id(1'b1, 29'h0BADBEEF)));
        check("R7 new data", rd_data, 64'hFEED);
        rearm(8'h80);
        peek(7);
        check("R7 rearm clears", 64'(rd_status), 64'(exp_st(1'b0, 1'b0, 1'b0, 4'd6)));
        send(1'b0, 1'b0, 29'h077, 4'd2, 64'hB7);
        peek(7);
        check("R7 refill without lost", 64'(rd_status), 64'(exp_st(1'b0, 1'b1, 1'b0, 4'd2)));
    endtask

    task automatic t_drop_full();
        set_mode(7, 3'd1);
        send(1'b0, 1'b0, 29'h321, 4'd4, 64'hDEAD);
        check("R8 drop when full", 64'(drop), 64'h1);
        check("R8 occupancy kept", 64'(ready_vec), 64'hBF);
        peek(7);
        check("R8 mb7 id kept", 64'(rd_id_word), 64'(exp_id(1'b0, 29'h077)));
        check("R8 mb7 data kept", rd_data, 64'hB7);
    endtask

    task automatic t_same_cycle();
        send(1'b0, 1'b0, 29'h444, 4'd1, 64'hC0, 1'b1, 8'h01);
        check("R10 frame sees old occupancy", 64'(drop), 64'h1);
        check("R10 rearm applied", 64'(ready_vec), 64'hBE);
        send(1'b0, 1'b0, 29'h445, 4'd1, 64'hC1);
        check("R10 next frame to mb0", 64'(ready_vec), 64'hBF);
        peek(0);
        check("R10 mb0 data", rd_data, 64'hC1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_off_drops();
        t_lowest_fill();
        t_multi_rearm();
        t_overwrite();
        t_drop_full();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule